// File: doc/BRIEF.md
# PWM Event Trigger Prescaler

This block sits beside a PWM time-base counter. It turns the counter's event strobes into two outputs: a start-of-conversion pulse for an ADC, and a level interrupt request. Each output channel has its own enable bit, its own event select code and its own 2-bit prescale value. The select code picks one event source. For the compare matches, the code also names the count direction in which the match has to happen.

Each channel counts the events it has selected. It acts when the count reaches the prescale value, so it can act on every event, every second event or every third event. For example, with the period event running at about 60.1 kHz and a prescale of 3, conversions start at about 20.03 kHz.

The conversion output is a single-clock pulse and needs no acknowledgement. The interrupt output is a latched flag. The flag stays set until software writes one to the clear input. While the flag is set, the interrupt counter parks at its prescale value and no new interrupt is raised.

Top module: `pwm_evt_trig`

## Requirements
- R1: After reset, `soc_pulse` and `irq_req` are 0 and both event counters are 0.
- R2: The select codes are 1 for counter zero, 2 for counter equal to period, 4 for a compare A match while counting up (`tb_up`=1), 5 for a compare A match while counting down (`tb_up`=0), 6 for a compare B match counting up and 7 for a compare B match counting down. Codes 0 and 3 select no event.
- R3: With a prescale value N of 1, 2 or 3, a channel acts on the Nth selected event after its counter was last 0, and its counter then restarts from 0.
- R4: A prescale value of 0 disables the channel's output and holds its counter at 0.
- R5: `soc_pulse` is high for exactly the one clock cycle after the clock edge that sampled the event on which the channel acts.
- R6: `irq_req` rises in the cycle after the acting event. It then stays high until a cycle in which `irq_clr` is 1, and it is low from the next cycle on.
- R7: While `irq_req` is high, further selected events move the interrupt counter up to the prescale value and hold it there, and no new interrupt is raised. After the clear, the first selected event raises the interrupt again if the counter was parked at the prescale value.
- R8: While a channel's enable is 0, its counter is held at 0 and it does not act. Clearing `irq_en` leaves a pending `irq_req` set.
- R9: The two channels are independent: the same strobe can advance one channel without affecting the other's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_zero | input | 1 | Time-base counter equals zero strobe |
| tb_prd | input | 1 | Time-base counter equals period strobe |
| tb_cmpa | input | 1 | Compare A match strobe |
| tb_cmpb | input | 1 | Compare B match strobe |
| tb_up | input | 1 | Count direction, 1 = counting up |
| soc_en | input | 1 | Conversion channel enable |
| soc_sel | input | 3 | Conversion channel event select code |
| soc_pre | input | 2 | Conversion channel prescale value |
| irq_en | input | 1 | Interrupt channel enable |
| irq_sel | input | 3 | Interrupt channel event select code |
| irq_pre | input | 2 | Interrupt channel prescale value |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| soc_pulse | output | 1 | Start-of-conversion pulse, one clock wide |
| irq_req | output | 1 | Latched interrupt request |

## Verification
The assertions take configuration as sampled at the same edge as the strobe it qualifies. They also assume the clear strobe is applied only through `irq_clr`, so the flag can fall only on a clear. The bench changes select, prescale and enable values only at the falling edge, just like the strobes. In the random phase it puts a disabled cycle between configuration changes, so each new setting starts from a counter of 0. The bench applies any mix of strobes and directions, including several strobes in one cycle, because each channel picks just one source.

// File: rtl/evt_trig_pkg.sv
// Shared definitions for the PWM event trigger prescaler.
// Assumes a 3-bit select code and a narrow prescale field.
package evt_trig_pkg;

    localparam int SEL_W = 3;
    localparam int PRE_W = 2;

    // Event select codes; the values are decoded by evt_select.
    typedef enum logic [SEL_W-1:0] {
        EV_NONE  = 3'd0,
        EV_ZERO  = 3'd1,
        EV_PRD   = 3'd2,
        EV_RSVD  = 3'd3,
        EV_CA_UP = 3'd4,
        EV_CA_DN = 3'd5,
        EV_CB_UP = 3'd6,
        EV_CB_DN = 3'd7
    } evt_code_e;

    // Per-channel configuration bundle.
    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [PRE_W-1:0] pre;
    } chan_cfg_t;

endpackage

// File: rtl/evt_select.sv
// Event source selector: maps a select code to one time-base strobe.
// Compare matches are qualified by count direction; unused codes select nothing.
// Assumes the strobes are single-cycle and synchronous to the block clock.
module evt_select
    import evt_trig_pkg::*;
(
    input  logic             zero_i,
    input  logic             prd_i,
    input  logic             cmpa_i,
    input  logic             cmpb_i,
    input  logic             up_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             evt_o
);

    // Decode the select code into a single event strobe.
    always_comb begin
        case (evt_code_e'(sel_i))
            EV_ZERO:  evt_o = zero_i;
            EV_PRD:   evt_o = prd_i;
            EV_CA_UP: evt_o = cmpa_i &  up_i;
            EV_CA_DN: evt_o = cmpa_i & ~up_i;
            EV_CB_UP: evt_o = cmpb_i &  up_i;
            EV_CB_DN: evt_o = cmpb_i & ~up_i;
            default:  evt_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/evt_prescale.sv
// Event prescaler: counts selected events and acts on the Nth one.
// LATCH=0 gives a one-clock pulse output. LATCH=1 gives a flag that holds
// until clr_i; while the flag is set, the counter parks at the prescale value.
// Assumes pre_i and en_i are stable in the cycle an event is sampled.
module evt_prescale #(
    parameter int PRE_W = 2,
    parameter bit LATCH = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [PRE_W-1:0] pre_i,
    input  logic             evt_i,
    input  logic             clr_i,
    output logic             out_o
);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W:0]   nxt;
    logic [PRE_W:0]   pre_x;
    logic             active;
    logic             blocked;
    logic             reach;
    logic             fire;

    assign nxt    = {1'b0, cnt} + 1'b1;
    assign pre_x  = {1'b0, pre_i};
    assign active = en_i && (pre_i != '0);
    assign reach  = (nxt >= pre_x);
    assign fire   = active && evt_i && !blocked && reach;

    // Event counter: clears when idle, restarts on fire, parks while blocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (evt_i) begin
            if (fire) begin
                cnt <= '0;
            end else if (blocked && reach) begin
                cnt <= pre_i;
            end else begin
                cnt <= nxt[PRE_W-1:0];
            end
        end
    end

    generate
        if (LATCH) begin : g_flag
            logic flag;
            // Interrupt flag: set on fire, cleared by write-one-to-clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag <= 1'b0;
                end else if (fire) begin
                    flag <= 1'b1;
                end else if (clr_i) begin
                    flag <= 1'b0;
                end
            end
            assign blocked = flag;
            assign out_o   = flag;
        end else begin : g_pulse
            logic pls;
            logic unused_clr;
            assign unused_clr = clr_i;
            // Pulse register: high for the single cycle after a fire.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pls <= 1'b0;
                end else begin
                    pls <= fire;
                end
            end
            assign blocked = 1'b0;
            assign out_o   = pls;
        end
    endgenerate

endmodule

// File: rtl/pwm_evt_trig.sv
// PWM event trigger prescaler top. Channel 0 drives the ADC start-of-conversion
// pulse; channel 1 drives the latched interrupt request. Each channel has its own
// selector and prescaler. Assumes all inputs are synchronous to clk.
module pwm_evt_trig
    import evt_trig_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_zero,
    input  logic             tb_prd,
    input  logic             tb_cmpa,
    input  logic             tb_cmpb,
    input  logic             tb_up,
    input  logic             soc_en,
    input  logic [SEL_W-1:0] soc_sel,
    input  logic [PRE_W-1:0] soc_pre,
    input  logic             irq_en,
    input  logic [SEL_W-1:0] irq_sel,
    input  logic [PRE_W-1:0] irq_pre,
    input  logic             irq_clr,
    output logic             soc_pulse,
    output logic             irq_req
);

    localparam int CH_SOC = 0;
    localparam int CH_IRQ = NCH - 1;

    chan_cfg_t cfg [NCH];
    logic [NCH-1:0] evt;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] outs;

    // Gather per-channel configuration into a uniform array.
    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            cfg[i] = '0;
            clr[i] = 1'b0;
        end
        cfg[CH_SOC] = '{en: soc_en, sel: soc_sel, pre: soc_pre};
        cfg[CH_IRQ] = '{en: irq_en, sel: irq_sel, pre: irq_pre};
        clr[CH_IRQ] = irq_clr;
    end

    generate
        for (genvar g = 0; g < NCH; g++) begin : g_ch
            evt_select u_sel (
                .zero_i (tb_zero),
                .prd_i  (tb_prd),
                .cmpa_i (tb_cmpa),
                .cmpb_i (tb_cmpb),
                .up_i   (tb_up),
                .sel_i  (cfg[g].sel),
                .evt_o  (evt[g])
            );
            evt_prescale #(
                .PRE_W (PRE_W),
                .LATCH (g == CH_IRQ)
            ) u_pre (
                .clk   (clk),
                .rst_n (rst_n),
                .en_i  (cfg[g].en),
                .pre_i (cfg[g].pre),
                .evt_i (evt[g]),
                .clr_i (clr[g]),
                .out_o (outs[g])
            );
        end
    endgenerate

    assign soc_pulse = outs[CH_SOC];
    assign irq_req   = outs[CH_IRQ];

endmodule

// File: rtl/evt_trig_chk.sv
// Assertion checker for pwm_evt_trig, attached by bind. It sees only ports.
module evt_trig_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       soc_en,
    input logic [2:0] soc_sel,
    input logic [1:0] soc_pre,
    input logic       irq_en,
    input logic       irq_clr,
    input logic       soc_pulse,
    input logic       irq_req
);

    AST_SOC_INVALID_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (soc_sel == 3'd0 || soc_sel == 3'd3) |=> !soc_pulse); // R2

    AST_SOC_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        soc_pulse |-> ($past(soc_en) && $past(soc_pre) != 2'd0)); // R3

    AST_SOC_PRE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (soc_pre == 2'd0) |=> !soc_pulse); // R4

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !irq_clr) |=> irq_req); // R6

    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_clr) |=> !irq_req); // R7

    AST_IRQ_RISE_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(irq_en)); // R8

endmodule

bind pwm_evt_trig evt_trig_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .soc_en    (soc_en),
    .soc_sel   (soc_sel),
    .soc_pre   (soc_pre),
    .irq_en    (irq_en),
    .irq_clr   (irq_clr),
    .soc_pulse (soc_pulse),
    .irq_req   (irq_req)
);

// File: tb/sim_pwm_evt_trig.sv
module sim_pwm_evt_trig;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 60000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_zero = 0, tb_prd = 0, tb_cmpa = 0, tb_cmpb = 0, tb_up = 0;
    logic soc_en = 0, irq_en = 0, irq_clr = 0;
    logic [2:0] soc_sel = 0, irq_sel = 0;
    logic [1:0] soc_pre = 0, irq_pre = 0;
    logic soc_pulse, irq_req;

    int total = 0, bad = 0, cycles = 0, soc_seen = 0;
    bit done = 0;

    // reference model state
    int m_scnt = 0, m_icnt = 0;
    bit m_sp = 0, m_if = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_evt_trig u0 (
        .clk(clk), .rst_n(rst_n), .tb_zero(tb_zero), .tb_prd(tb_prd),
        .tb_cmpa(tb_cmpa), .tb_cmpb(tb_cmpb), .tb_up(tb_up),
        .soc_en(soc_en), .soc_sel(soc_sel), .soc_pre(soc_pre),
        .irq_en(irq_en), .irq_sel(irq_sel), .irq_pre(irq_pre),
        .irq_clr(irq_clr), .soc_pulse(soc_pulse), .irq_req(irq_req)
    );

    function automatic bit picked(input logic [2:0] code);
        case (code)
            3'd1: return tb_zero;
            3'd2: return tb_prd;
            3'd4: return tb_cmpa && tb_up;
            3'd5: return tb_cmpa && !tb_up;
            3'd6: return tb_cmpb && tb_up;
            3'd7: return tb_cmpb && !tb_up;
            default: return 0;
        endcase
    endfunction

    // behavioural model, updated at each rising edge
    always @(posedge clk) begin
        bit fire;
        if (!rst_n) begin
            m_scnt = 0; m_icnt = 0; m_sp = 0; m_if = 0;
        end else begin
            m_sp = 0;
            if (!soc_en || soc_pre == 0) m_scnt = 0;
            else if (picked(soc_sel)) begin
                if (m_scnt + 1 >= int'(soc_pre)) begin m_sp = 1; m_scnt = 0; end
                else m_scnt++;
            end
            fire = 0;
            if (!irq_en || irq_pre == 0) m_icnt = 0;
            else if (picked(irq_sel)) begin
                if (m_if) m_icnt = (m_icnt + 1 >= int'(irq_pre)) ? int'(irq_pre) : m_icnt + 1;
                else if (m_icnt + 1 >= int'(irq_pre)) begin fire = 1; m_icnt = 0; end
                else m_icnt++;
            end
            if (fire) m_if = 1;
            else if (irq_clr) m_if = 0;
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (soc_pulse === 1'b1) soc_seen++;
        if (rst_n && !done) begin
            total += 2;
            if (soc_pulse !== m_sp) begin
                bad++;
                $display("FAIL R5 soc_pulse per-cycle: actual=%0b expected=%0b t=%0t", soc_pulse, m_sp, $time);
            end
            if (irq_req !== m_if) begin
                bad++;
                $display("FAIL R6 irq_req per-cycle: actual=%0b expected=%0b t=%0t", irq_req, m_if, $time);
            end
        end
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one-cycle strobe followed by a quiet cycle
    task automatic ev(input bit z, input bit p, input bit a, input bit b, input bit up);
        @(negedge clk);
        tb_zero = z; tb_prd = p; tb_cmpa = a; tb_cmpb = b; tb_up = up;
        @(negedge clk);
        tb_zero = 0; tb_prd = 0; tb_cmpa = 0; tb_cmpb = 0;
    endtask

    task automatic soc_cfg(input logic [2:0] s, input logic [1:0] p);
        @(negedge clk);
        soc_en = 0; soc_sel = s; soc_pre = p;
        @(negedge clk);
        soc_en = 1;
    endtask

    task automatic settle_count(output int v);
        idle(2); #1; v = soc_seen;
    endtask

    initial begin
        int base, now;
        idle(3);
        rst_n = 1;
        #1;
        check("R1 soc_pulse after reset", soc_pulse, 0);
        check("R1 irq_req after reset", irq_req, 0);

        // R3: prescale 3 on period events, zero strobes must not count
        soc_cfg(3'd2, 2'd3);
        settle_count(base);
        for (int i = 0; i < 9; i++) begin ev(0, 1, 0, 0, 1); ev(1, 0, 0, 0, 1); end
        settle_count(now);
        check("R3 prescale 3 gives 3 pulses from 9", now - base, 3);

        soc_cfg(3'd2, 2'd1);
        settle_count(base);
        for (int i = 0; i < 4; i++) ev(0, 1, 0, 0, 0);
        settle_count(now);
        check("R3 prescale 1 gives 4 pulses from 4", now - base, 4);

        soc_cfg(3'd2, 2'd2);
        settle_count(base);
        for (int i = 0; i < 5; i++) ev(0, 1, 0, 0, 0);
        settle_count(now);
        check("R3 prescale 2 gives 2 pulses from 5", now - base, 2);

        // R4: prescale 0 disables
        soc_cfg(3'd2, 2'd0);
        settle_count(base);
        for (int i = 0; i < 6; i++) ev(0, 1, 0, 0, 0);
        settle_count(now);
        check("R4 prescale 0 gives no pulse", now - base, 0);

        // R2: each code against all six qualified strobes
        for (int c = 0; c < 8; c++) begin
            soc_cfg(3'(c), 2'd1);
            settle_count(base);
            ev(1, 0, 0, 0, 1);
            ev(0, 1, 0, 0, 1);
            ev(0, 0, 1, 0, 1);
            ev(0, 0, 1, 0, 0);
            ev(0, 0, 0, 1, 1);
            ev(0, 0, 0, 1, 0);
            settle_count(now);
            check($sformatf("R2 select code %0d pulse count", c), now - base,
                  (c == 0 || c == 3) ? 0 : 1);
        end

        // R5: single-cycle pulse timing
        soc_cfg(3'd1, 2'd1);
        @(negedge clk); tb_zero = 1;
        @(negedge clk); tb_zero = 0; #1;
        check("R5 pulse high in cycle after event", soc_pulse, 1);
        @(negedge clk); #1;
        check("R5 pulse low one cycle later", soc_pulse, 0);

        // R8: disabling restarts the counter
        soc_cfg(3'd2, 2'd3);
        settle_count(base);
        ev(0, 1, 0, 0, 0); ev(0, 1, 0, 0, 0);
        @(negedge clk); soc_en = 0;
        @(negedge clk); soc_en = 1;
        ev(0, 1, 0, 0, 0); ev(0, 1, 0, 0, 0);
        settle_count(now);
        check("R8 counter restarted after disable", now - base, 0);
        ev(0, 1, 0, 0, 0);
        settle_count(now);
        check("R8 third event after re-enable pulses", now - base, 1);

        // R6: latched interrupt, write-one-to-clear
        @(negedge clk); soc_en = 0; irq_sel = 3'd1; irq_pre = 2'd2; irq_en = 1;
        ev(1, 0, 0, 0, 0); #1;
        check("R6 no irq after first of two", irq_req, 0);
        ev(1, 0, 0, 0, 0); #1;
        check("R6 irq set after second event", irq_req, 1);
        idle(5); #1;
        check("R6 irq held without clear", irq_req, 1);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0; #1;
        check("R6 irq cleared by write-one", irq_req, 0);

        // R7: block while set, park counter, fire on first event after clear
        ev(1, 0, 0, 0, 0); ev(1, 0, 0, 0, 0); #1;
        check("R7 irq set again", irq_req, 1);
        for (int i = 0; i < 5; i++) ev(1, 0, 0, 0, 0);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0; idle(2); #1;
        check("R7 no immediate re-raise after clear", irq_req, 0);
        ev(1, 0, 0, 0, 0); #1;
        check("R7 parked counter fires on next event", irq_req, 1);

        // R8: clearing irq_en keeps a pending flag
        @(negedge clk); irq_en = 0;
        idle(3); #1;
        check("R8 flag kept after irq_en cleared", irq_req, 1);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0; #1;
        check("R8 flag clears with enable off", irq_req, 0);

        // R9: channel independence
        soc_cfg(3'd2, 2'd1);
        @(negedge clk); irq_sel = 3'd1; irq_pre = 2'd1; irq_en = 1;
        settle_count(base);
        ev(0, 1, 0, 0, 0); #1;
        check("R9 irq untouched by soc-only event", irq_req, 0);
        settle_count(now);
        check("R9 soc pulsed on its event", now - base, 1);
        ev(1, 0, 0, 0, 0); #1;
        check("R9 irq set by its own event", irq_req, 1);

        // random phase, checked cycle by cycle against the model
        for (int blk = 0; blk < 40; blk++) begin
            @(negedge clk);
            soc_en = 0; irq_en = 0;
            soc_sel = 3'($urandom); soc_pre = 2'($urandom);
            irq_sel = 3'($urandom); irq_pre = 2'($urandom);
            @(negedge clk);
            soc_en = 1; irq_en = 1;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                tb_zero = 1'($urandom); tb_prd = 1'($urandom);
                tb_cmpa = 1'($urandom); tb_cmpb = 1'($urandom);
                tb_up = 1'($urandom);
                irq_clr = (($urandom % 8) == 0);
            end
            tb_zero = 0; tb_prd = 0; tb_cmpa = 0; tb_cmpb = 0; irq_clr = 0;
        end

        idle(3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule